// File: doc/BRIEF.md
# Auto-Reload Down Timer with Edge-Armed Start

This block is an 8-bit down-counter that reloads itself. Each time it passes below zero it takes a fresh value from its reload register. It raises a sticky interrupt flag and emits a one-cycle underflow pulse. That pulse can drive the cascade input of another instance, so timers can be chained. The counter advances on one of four single-cycle tick sources, all on one system clock:

- the output of a built-in 8-bit auto-reloading prescaler;
- the instruction-clock enable;
- rising edges of an external count pin;
- another timer's underflow.

The run state is held by a small state machine with three states.

- `ST_STOP`: idle. The counter holds, and a reload write also loads the counter.
- `ST_ARMED`: waiting for a trigger edge.
- `ST_RUN`: counting.

The state machine has these transitions:

- **start**: `ST_STOP` to `ST_RUN`, when run is set and wait is clear.
- **arm**: `ST_STOP` to `ST_ARMED`, when run and wait are both set.
- **fire**: `ST_ARMED` to `ST_RUN`, on a qualifying trigger edge, or when wait is cleared.
- **halt**: `ST_ARMED` or `ST_RUN` to `ST_STOP`, when run is cleared.

The halt transition also forgets any trigger that was seen. The trigger edge can be rising, falling or both. Both pins pass through a two-flop synchroniser before edge detection.

Software drives the block through one write port. `wr_sel` picks the target:

| `wr_sel` | Target |
|---|---|
| 0 | control register |
| 1 | timer reload register |
| 2 | prescaler reload register |
| 3 | nothing |

The control register fields are:

| Bits | Field | Meaning |
|---|---|---|
| 1:0 | source select | 00 prescaler, 01 instruction tick, 10 count-pin rise, 11 cascade input |
| 2 | run | enables the timer |
| 3 | wait | arms the start latch |
| 4 | trigger polarity | 1 rising, 0 falling |
| 5 | both edges | trigger on either edge |
| 6 | prescaler enable | lets the prescaler count |

Top module: `cascade_reload_timer`

## Requirements
- R1: In `ST_RUN`, each tick of the selected source lowers a nonzero count by one. In any other state the count is unchanged, except for a reload write in `ST_STOP`. Reset leaves count 0, flag 0, pulse 0 and `ST_STOP`.
- R2: A tick while the count is 0 loads the reload value. With reload N and one tick per cycle, underflows come every N+1 cycles.
- R3: `underflow` is high for exactly the one cycle after the underflowing tick.
- R4: An underflow sets `irq_flag`, which stays set until `flag_clr` is high. If both happen in the same cycle, the set wins.
- R5: Source select 00/01/10/11 picks prescaler tick, `instr_tick`, count-pin rising edge and `cascade_in` respectively. Unselected sources have no effect.
- R6: With run (bit 2) at 0 the state goes to `ST_STOP` and the count holds. A stored trigger is discarded, so re-arming needs a new edge.
- R7: With run and wait (bit 3) set, the block stays in `ST_ARMED` without counting until a trigger edge. Bit 4 set selects the rising edge and bit 4 clear selects the falling edge.
- R8: With bit 5 set, either trigger edge fires the start.
- R9: With run set and wait clear, counting starts two cycles after the control write, with no trigger.
- R10: A reload write in `ST_STOP` also loads the counter. In `ST_ARMED` or `ST_RUN` it changes only the reload register, which is used at the next underflow.
- R11: When bit 6 is set, the prescaler counts `instr_tick` and ticks every P+1 of them, where P is its reload value. When bit 6 is clear it holds, and a prescaler reload write also loads it.
- R12: A trigger pin change made between clock edges reaches `counting` on the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_tick | input | 1 | Instruction-clock enable pulse |
| count_pin | input | 1 | Asynchronous external count pin |
| trig_pin | input | 1 | Asynchronous start trigger pin |
| cascade_in | input | 1 | Underflow pulse from a neighbouring timer |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload, 2 prescaler reload |
| wr_data | input | WR_W | Write data |
| flag_clr | input | 1 | Clears the interrupt flag |
| count | output | CNT_W | Current counter value |
| underflow | output | 1 | One-cycle underflow pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| counting | output | 1 | High in `ST_RUN` |

## Verification
The assertions check several rules on every cycle:

- a step lowers the count by one, and an underflow leaves the previous reload value in place;
- the count holds outside `ST_RUN`;
- an underflow pulse always finds the flag set;
- clearing run forces the state out of `ST_RUN`;
- `ST_ARMED` persists without an edge;
- the prescaler reloads correctly.

Some behaviours only the bench scenarios can show. These are the underflow period for a given reload, and the trigger polarity and both-edge choices. They also include the synchroniser latency, the rejection of unselected sources, and that a stale trigger is dropped after a halt.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        SRC_PRESCALE = 2'b00,
        SRC_INSTR    = 2'b01,
        SRC_PIN      = 2'b10,
        SRC_CASCADE  = 2'b11
    } src_sel_e;

    // control register image, bit 0 at the bottom
    typedef struct packed {
        logic     ps_en;
        logic     both_edges;
        logic     rise_pol;
        logic     wait_start;
        logic     run;
        src_sel_e src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] WR_CTRL     = 2'd0;
    localparam logic [1:0] WR_RELOAD   = 2'd1;
    localparam logic [1:0] WR_PSRELOAD = 2'd2;

endpackage

// File: rtl/crt_sync_edge.sv
module crt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_en,
    input  logic fall_en,
    output logic edge_hit
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             level;
    logic             prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pin_async};
        end
    end

    always_comb begin
        level    = chain_q[STAGES-1];
        prev     = chain_q[STAGES];
        edge_hit = (rise_en && level && !prev) || (fall_en && !level && prev);
    end

endmodule

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         step,
    input  logic         load_wr,
    input  logic [W-1:0] load_val,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] reload_q;
    logic         tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (load_wr) begin
            reload_q <= load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (enable && step) begin
                if (cnt_q == '0) begin
                    cnt_q  <= reload_q;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - W'(1);
                end
            end else if (load_wr && !enable) begin
                cnt_q <= load_val;
            end
        end
    end

    assign tick = tick_q;

    // R11
    ps_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> cnt_q == $past(reload_q));

endmodule

// File: rtl/crt_src_mux.sv
module crt_src_mux import crt_pkg::*; (
    input  src_sel_e sel,
    input  logic     ps_tick,
    input  logic     instr_tick,
    input  logic     pin_rise,
    input  logic     cascade_in,
    output logic     tick
);
    always_comb begin
        unique case (sel)
            SRC_PRESCALE: tick = ps_tick;
            SRC_INSTR:    tick = instr_tick;
            SRC_PIN:      tick = pin_rise;
            SRC_CASCADE:  tick = cascade_in;
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core import crt_pkg::*; #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wait_start,
    input  logic         trig_hit,
    input  logic         src_tick,
    input  logic         reload_wr,
    input  logic [W-1:0] reload_val,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic         underflow,
    output logic         irq_flag,
    output logic         counting
);
    run_state_e   state_q;
    run_state_e   state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] reload_q;
    logic         uf_q;
    logic         flag_q;
    logic         step;
    logic         at_zero;
    logic         wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, arm, fire, halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (run) begin
                    state_d = wait_start ? ST_ARMED : ST_RUN;
                end
            end
            ST_ARMED: begin
                if (!run) begin
                    state_d = ST_STOP;
                end else if (trig_hit || !wait_start) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!run) begin
                    state_d = ST_STOP;
                end
            end
            default: state_d = ST_STOP;
        endcase
    end

    // state-derived outputs
    always_comb begin
        counting = (state_q == ST_RUN);
        step     = counting && src_tick;
        at_zero  = (cnt_q == '0);
        wrap     = step && at_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (reload_wr) begin
            reload_q <= reload_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            uf_q  <= 1'b0;
        end else begin
            uf_q <= wrap;
            if (step) begin
                cnt_q <= at_zero ? reload_q : cnt_q - W'(1);
            end else if (reload_wr && state_q == ST_STOP) begin
                cnt_q <= reload_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign count     = cnt_q;
    assign underflow = uf_q;
    assign irq_flag  = flag_q;

    // R1
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_zero) |=> count == $past(count) - W'(1));

    // R2
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> count == $past(reload_q));

    // R4
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> irq_flag);

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !reload_wr) |=> $stable(count));

    // R6
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !counting);

    // R7
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && run && wait_start && !trig_hit) |=> state_q == ST_ARMED);

endmodule

// File: rtl/cascade_reload_timer.sv
module cascade_reload_timer import crt_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int PS_W        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WIDE_W     = (CNT_W > PS_W) ? CNT_W : PS_W,
    localparam int WR_W       = (WIDE_W > CTRL_W) ? WIDE_W : CTRL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_tick,
    input  logic             count_pin,
    input  logic             trig_pin,
    input  logic             cascade_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             underflow,
    output logic             irq_flag,
    output logic             counting
);
    ctrl_t ctrl_q;
    logic  ctrl_wr;
    logic  reload_wr;
    logic  ps_wr;
    logic  trig_rise_en;
    logic  trig_fall_en;
    logic  trig_hit;
    logic  pin_rise;
    logic  ps_tick;
    logic  src_tick;

    always_comb begin
        ctrl_wr      = wr_en && (wr_sel == WR_CTRL);
        reload_wr    = wr_en && (wr_sel == WR_RELOAD);
        ps_wr        = wr_en && (wr_sel == WR_PSRELOAD);
        trig_rise_en = ctrl_q.both_edges || ctrl_q.rise_pol;
        trig_fall_en = ctrl_q.both_edges || !ctrl_q.rise_pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    crt_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(trig_pin),
        .rise_en  (trig_rise_en),
        .fall_en  (trig_fall_en),
        .edge_hit (trig_hit)
    );

    crt_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(count_pin),
        .rise_en  (1'b1),
        .fall_en  (1'b0),
        .edge_hit (pin_rise)
    );

    crt_prescaler #(.W(PS_W)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_q.ps_en),
        .step    (instr_tick),
        .load_wr (ps_wr),
        .load_val(wr_data[PS_W-1:0]),
        .tick    (ps_tick)
    );

    crt_src_mux u_src_mux (
        .sel       (ctrl_q.src),
        .ps_tick   (ps_tick),
        .instr_tick(instr_tick),
        .pin_rise  (pin_rise),
        .cascade_in(cascade_in),
        .tick      (src_tick)
    );

    crt_count_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.run),
        .wait_start(ctrl_q.wait_start),
        .trig_hit  (trig_hit),
        .src_tick  (src_tick),
        .reload_wr (reload_wr),
        .reload_val(wr_data[CNT_W-1:0]),
        .flag_clr  (flag_clr),
        .count     (count),
        .underflow (underflow),
        .irq_flag  (irq_flag),
        .counting  (counting)
    );

endmodule

// File: tb/tb_cascade_reload_timer.sv
`timescale 1ns/1ps
module tb_cascade_reload_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_tick = 1'b0;
    logic       count_pin = 1'b0;
    logic       trig_pin = 1'b0;
    logic       cascade_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] count;
    logic       underflow;
    logic       irq_flag;
    logic       counting;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int last_uf = -1;
    int last_period = 0;
    int uf_total = 0;
    int uf_run = 0;
    int uf_maxrun = 0;

    always #2.5 clk = ~clk;

    cascade_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick), .count_pin(count_pin),
        .trig_pin(trig_pin), .cascade_in(cascade_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .count(count), .underflow(underflow),
        .irq_flag(irq_flag), .counting(counting)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_state = 0;        // 0 stop, 1 armed, 2 run
    bit [7:0] m_cnt = 0, m_rel = 0, m_ps = 0, m_psrel = 0, m_ctrl = 0;
    bit       m_uf = 0, m_flag = 0, m_pst = 0;
    bit [2:0] m_t = 0, m_c = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_rel = 0; m_ps = 0; m_psrel = 0; m_ctrl = 0;
            m_uf = 0; m_flag = 0; m_pst = 0; m_t = 0; m_c = 0;
        end else begin : mdl
            bit t_rise, t_fall, trig, c_rise, tick, step, n_uf, n_flag, n_pst;
            int n_state;
            bit [7:0] n_cnt, n_ps;
            t_rise = m_t[1] && !m_t[2];
            t_fall = !m_t[1] && m_t[2];
            trig = m_ctrl[5] ? (t_rise || t_fall) : (m_ctrl[4] ? t_rise : t_fall);
            c_rise = m_c[1] && !m_c[2];
            case (m_ctrl[1:0])
                2'b00: tick = m_pst;
                2'b01: tick = instr_tick;
                2'b10: tick = c_rise;
                default: tick = cascade_in;
            endcase
            step = (m_state == 2) && tick;
            if (!m_ctrl[2]) n_state = 0;
            else if (m_state == 0) n_state = m_ctrl[3] ? 1 : 2;
            else if (m_state == 1) n_state = (trig || !m_ctrl[3]) ? 2 : 1;
            else n_state = 2;
            n_cnt = m_cnt; n_uf = 0; n_flag = m_flag;
            if (step) begin
                if (m_cnt == 0) begin n_cnt = m_rel; n_uf = 1; n_flag = 1; end
                else n_cnt = m_cnt - 1;
            end else if (wr_en && wr_sel == 2'd1 && m_state == 0) n_cnt = wr_data;
            if (!n_uf && flag_clr) n_flag = 0;
            n_ps = m_ps; n_pst = 0;
            if (m_ctrl[6] && instr_tick) begin
                if (m_ps == 0) begin n_ps = m_psrel; n_pst = 1; end
                else n_ps = m_ps - 1;
            end else if (wr_en && wr_sel == 2'd2 && !m_ctrl[6]) n_ps = wr_data;
            if (wr_en && wr_sel == 2'd0) m_ctrl = {1'b0, wr_data[6:0]};
            if (wr_en && wr_sel == 2'd1) m_rel = wr_data;
            if (wr_en && wr_sel == 2'd2) m_psrel = wr_data;
            m_t = {m_t[1:0], trig_pin};
            m_c = {m_c[1:0], count_pin};
            m_state = n_state; m_cnt = n_cnt; m_uf = n_uf; m_flag = n_flag;
            m_ps = n_ps; m_pst = n_pst;
        end
    end

    // per-cycle comparison and underflow tracking
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            chk_eq("R1", "count vs model", count, m_cnt);
            chk_eq("R3", "underflow vs model", underflow, m_uf);
            chk_eq("R4", "irq_flag vs model", irq_flag, m_flag);
            chk_eq("R7", "counting vs model", counting, m_state == 2);
            if (underflow) begin
                if (last_uf >= 0) last_period = cyc - last_uf;
                last_uf = cyc;
                uf_total++;
                uf_run++;
                if (uf_run > uf_maxrun) uf_maxrun = uf_run;
            end else begin
                uf_run = 0;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] mk_ctrl(input logic [1:0] src, input logic run, input logic wt,
                                           input logic rise, input logic both, input logic ps);
        return {1'b0, ps, both, rise, wt, run, src};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin : main
        int c;
        int base;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // reset state
        chk_eq("R1", "reset count", count, 0);
        chk_eq("R4", "reset flag", irq_flag, 0);
        chk_eq("R3", "reset underflow", underflow, 0);
        chk_eq("R1", "reset counting", counting, 0);

        // R10 load while stopped
        wr(2'd1, 8'd5);
        chk_eq("R10", "stopped reload write loads count", count, 5);

        // R9, R2, R3, R5 instruction tick source
        instr_tick = 1'b1;
        wr(2'd0, mk_ctrl(2'b01, 1, 0, 0, 0, 0));
        wait_cyc(1);
        chk_eq("R9", "free start counting", counting, 1);
        wait_cyc(40);
        chk_eq("R2", "period reload 5", last_period, 6);
        chk_eq("R3", "single-cycle pulse", uf_maxrun, 1);
        instr_tick = 1'b0;
        wait_cyc(12);
        chk_eq("R4", "flag sticky", irq_flag, 1);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk_eq("R4", "flag cleared", irq_flag, 0);

        // R10 write while running
        c = count;
        wr(2'd1, 8'd2);
        chk_eq("R10", "running reload write keeps count", count, c);
        instr_tick = 1'b1;
        wait_cyc(30);
        chk_eq("R10", "new reload used after wrap", last_period, 3);

        // R6 halt
        wr(2'd0, mk_ctrl(2'b01, 0, 0, 0, 0, 0));
        wait_cyc(2);
        c = count;
        wait_cyc(10);
        chk_eq("R6", "halted count holds", count, c);
        chk_eq("R6", "halted not counting", counting, 0);

        // R7 rising trigger, R12 latency
        wr(2'd0, mk_ctrl(2'b01, 1, 1, 1, 0, 0));
        wait_cyc(5);
        c = count;
        wait_cyc(10);
        chk_eq("R7", "armed count holds", count, c);
        chk_eq("R7", "armed not counting", counting, 0);
        trig_pin = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk_eq("R12", "not yet after two edges", counting, 0);
        @(posedge clk); #1;
        chk_eq("R12", "running on third edge", counting, 1);

        // R7 falling polarity
        wr(2'd0, 8'd0);
        trig_pin = 1'b0;
        wait_cyc(5);
        wr(2'd0, mk_ctrl(2'b01, 1, 1, 0, 0, 0));
        wait_cyc(5);
        trig_pin = 1'b1;
        wait_cyc(8);
        chk_eq("R7", "rising ignored in falling mode", counting, 0);
        trig_pin = 1'b0;
        wait_cyc(8);
        chk_eq("R7", "falling starts", counting, 1);

        // R8 both edges, R6 stale trigger dropped
        wr(2'd0, 8'd0);
        wr(2'd0, mk_ctrl(2'b01, 1, 1, 0, 1, 0));
        wait_cyc(8);
        chk_eq("R6", "no stale trigger after halt", counting, 0);
        trig_pin = 1'b1;
        wait_cyc(8);
        chk_eq("R8", "rise fires in both mode", counting, 1);
        wr(2'd0, 8'd0);
        wr(2'd0, mk_ctrl(2'b01, 1, 1, 1, 1, 0));
        wait_cyc(5);
        trig_pin = 1'b0;
        wait_cyc(8);
        chk_eq("R8", "fall fires in both mode", counting, 1);

        // R11 prescaler
        wr(2'd0, 8'd0);
        wr(2'd2, 8'd3);
        wr(2'd1, 8'd1);
        wr(2'd0, mk_ctrl(2'b00, 1, 0, 0, 0, 1));
        wait_cyc(100);
        chk_eq("R11", "prescaled period", last_period, 8);
        wr(2'd0, mk_ctrl(2'b00, 1, 0, 0, 0, 0));
        wait_cyc(3);
        c = count;
        wait_cyc(20);
        chk_eq("R11", "prescaler gated holds count", count, c);

        // R5 external pin source
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd2);
        wr(2'd0, mk_ctrl(2'b10, 1, 0, 0, 0, 0));
        wait_cyc(10);
        chk_eq("R5", "instr tick ignored on pin source", count, 2);
        base = uf_total;
        for (int i = 0; i < 3; i++) begin
            count_pin = 1'b1;
            wait_cyc(4);
            count_pin = 1'b0;
            wait_cyc(4);
            if (i == 0) chk_eq("R5", "one pin edge one step", count, 1);
        end
        chk_eq("R5", "pin wrap count", count, 2);
        chk_eq("R5", "pin wrap pulses", uf_total - base, 1);

        // R5 cascade source
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd4);
        wr(2'd0, mk_ctrl(2'b11, 1, 0, 0, 0, 0));
        wait_cyc(5);
        chk_eq("R5", "cascade idle holds", count, 4);
        @(negedge clk) cascade_in = 1'b1;
        @(negedge clk) cascade_in = 1'b0;
        wait_cyc(3);
        chk_eq("R5", "cascade pulse steps", count, 3);

        chk_eq("R3", "max pulse width", uf_maxrun, 1);
        finish_run();
    end

endmodule